// File: doc/BRIEF.md
# Channel Gain Stage with Ramp Envelope

This block scales one signed 16-bit sample stream by an 11-bit programmable gain and then by an envelope factor. A quadrature transmitter places one copy on the I path and one on the Q path, and each copy has its own gain and envelope settings. Samples arrive with a valid strobe. Each result leaves one clock later with its own strobe.

When the envelope is enabled, a ramp request starts an attack from zero that climbs to full scale. The output then stays at full scale for as long as the request stays high. Once the request is released, the envelope decays back to zero. A 7-bit index drives the ramp, and a 16-bit prescale sets how many sample strobes pass between index steps. A select input picks a straight-line envelope or an S-shaped one; the S-shaped curve keeps the spectrum tighter during fast ramps. While the envelope is disabled, only the gain is applied.

Top module: `gain_ramp_stage`

## Requirements
- R1: With `env_en_i` low, an accepted sample x gives floor(x * gain_i / 2048), where `gain_i` is an unsigned 11-bit value.
- R2: `valid_o` is `valid_i` delayed by one clock. `data_o` changes only in the clock that follows an accepted sample, and otherwise holds its value.
- R3: While `rst_ni` is low, `valid_o` and `data_o` are zero and the envelope sits in its idle state.
- R4: With the envelope enabled and idle (no ramp in progress), every accepted sample gives 0.
- R5: Raising `ramp_req_i` in idle starts an attack with the index at 0. The index moves by one after every `rate_i`+1 accepted samples. Clock cycles without `valid_i` do not count toward a step.
- R6: With `shape_i` = 0 (linear), the envelope during a ramp equals index/128.
- R7: With `shape_i` = 1 (S-shaped), the envelope during a ramp equals floor((384*i^2 - 2*i^3) / 2^14)/128 for index i.
- R8: When the index steps past 127 in the attack, the envelope becomes exactly 1.0. It stays there while `ramp_req_i` is high.
- R9: When `ramp_req_i` goes low during the hold, the decay starts at index 127 and counts down. When the index steps past 0, the block returns to idle and the output is 0.
- R10: With `env_en_i` low, the envelope is 1.0 from that same sample onward, and the ramp state returns to idle.
- R11: Both scaling steps round toward minus infinity (arithmetic truncation), and the result is limited to the signed 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| env_en_i | input | 1 | Envelope enable; low gives gain only |
| ramp_req_i | input | 1 | Ramp request: rising starts the attack, held keeps full scale, low starts the decay |
| shape_i | input | 1 | Envelope shape: 0 linear, 1 S-shaped |
| gain_i | input | 11 | Unsigned gain in steps of 1/2048 |
| rate_i | input | 16 | Accepted samples per index step, minus one |
| valid_i | input | 1 | Input sample strobe |
| data_i | input | 16 | Signed input sample |
| valid_o | output | 1 | Output sample strobe |
| data_o | output | 16 | Signed scaled sample |

## Verification
The bench drives negative samples with small gains. A design that truncates toward zero would give 0 where -1 is expected. It walks the full attack and decay at step rate zero and compares every sample against both envelope curves. This exposes an off-by-one at index 127, a hold that starts one step early, and a decay that does not start from the top. A run at prescale 3 with gaps in the strobe catches a prescale that counts clocks instead of samples, or one that steps every `rate_i` samples. Pulling the enable low in the middle of the attack checks two things: the full-scale override takes effect on that same sample, and the ramp does not resume when the enable comes back.

// File: rtl/gr_pkg.sv
package gr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_HOLD = 2'd2,
    ST_DOWN = 2'd3
  } env_state_e;
endpackage

// File: rtl/gr_env_ctrl.sv
module gr_env_ctrl
  import gr_pkg::*;
#(
  parameter int IDX_W  = 7,
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              req_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              valid_i,
  output env_state_e        state_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;

  env_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              ramping, step;

  assign ramping = (state_q == ST_UP) || (state_q == ST_DOWN);
  // >= so a rate lowered mid-ramp never lets the counter wrap
  assign step    = ramping && valid_i && (cnt_q >= rate_i);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i || !ramping || step) cnt_d = '0;
    else if (valid_i)              cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (!en_i) begin
      state_d = ST_IDLE;
      idx_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_d = ST_UP;
          idx_d   = '0;
        end
        ST_UP: if (step) begin
          if (idx_q == IDX_MAX) state_d = ST_HOLD;
          else                  idx_d   = idx_q + 1'b1;
        end
        ST_HOLD: if (!req_i) begin
          state_d = ST_DOWN;
          idx_d   = IDX_MAX;
        end
        ST_DOWN: if (step) begin
          if (idx_q == '0) state_d = ST_IDLE;
          else             idx_d   = idx_q - 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign idx_o   = idx_q;

  assert_up_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_UP && step && idx_q != IDX_MAX) |=> (idx_q == $past(idx_q) + 1'b1));

  // R5: cycles without a sample never move the index
  assert_no_gap_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !valid_i) |=> (idx_q == $past(idx_q)));

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_HOLD && req_i) |=> (state_q == ST_HOLD));

  assert_down_end_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && state_q == ST_DOWN && step && idx_q == '0) |=> (state_q == ST_IDLE));

  assert_disable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (state_q == ST_IDLE && idx_q == '0));
endmodule

// File: rtl/gr_env_shape.sv
module gr_env_shape
  import gr_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             en_i,
  input  logic             shape_i,
  input  env_state_e       state_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W:0]   env_o
);
  localparam int           NUM_W = 3 * IDX_W + 3;
  localparam logic [IDX_W:0] FULL = {1'b1, {IDX_W{1'b0}}};

  logic [NUM_W-1:0] i_ext, sq, cube, num;
  logic [IDX_W:0]   sig_env, lin_env, ramp_env;

  // smoothstep 3x^2 - 2x^3 with x = idx / 2^IDX_W
  always_comb begin
    i_ext = NUM_W'(idx_i);
    sq    = i_ext * i_ext;
    cube  = sq * i_ext;
    num   = (sq * NUM_W'(3 * (1 << IDX_W))) - (cube << 1);
  end

  assign sig_env  = num[2*IDX_W +: IDX_W+1];
  assign lin_env  = {1'b0, idx_i};
  assign ramp_env = shape_i ? sig_env : lin_env;

  always_comb begin
    if (!en_i) env_o = FULL;
    else begin
      unique case (state_i)
        ST_IDLE: env_o = '0;
        ST_HOLD: env_o = FULL;
        default: env_o = ramp_env;
      endcase
    end
  end
endmodule

// File: rtl/gr_gain_mul.sv
module gr_gain_mul #(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 11,
  parameter int IDX_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [IDX_W:0]    env_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int P1_W = DATA_W + GAIN_W + 1;
  localparam int P2_W = P1_W + IDX_W + 2;
  localparam logic signed [P2_W-1:0] MAX_V = P2_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [P2_W-1:0] MIN_V = P2_W'(-(2 ** (DATA_W - 1)));

  logic signed [P1_W-1:0]   p1, s1;
  logic signed [P2_W-1:0]   p2, s2;
  logic        [DATA_W-1:0] sat;

  always_comb begin
    p1 = $signed(data_i) * $signed({1'b0, gain_i});
    s1 = p1 >>> GAIN_W;
    p2 = s1 * $signed({1'b0, env_i});
    s2 = p2 >>> IDX_W;
    if (s2 > MAX_V)      sat = MAX_V[DATA_W-1:0];
    else if (s2 < MIN_V) sat = MIN_V[DATA_W-1:0];
    else                 sat = s2[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= sat;
    end
  end

  assert_strobe_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_hold_out_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(data_o)));

  // R11: non-negative factors never flip a non-negative sample negative
  assert_sign_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !data_i[DATA_W-1]) |=> !data_o[DATA_W-1]);
endmodule

// File: rtl/gain_ramp_stage.sv
module gain_ramp_stage
  import gr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int GAIN_W = 11,
  parameter int IDX_W  = 7,
  parameter int RATE_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              env_en_i,
  input  logic              ramp_req_i,
  input  logic              shape_i,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  env_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   env;

  gr_env_ctrl #(.IDX_W(IDX_W), .RATE_W(RATE_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (env_en_i),
    .req_i   (ramp_req_i),
    .rate_i  (rate_i),
    .valid_i (valid_i),
    .state_o (state),
    .idx_o   (idx)
  );

  gr_env_shape #(.IDX_W(IDX_W)) u_shape (
    .en_i    (env_en_i),
    .shape_i (shape_i),
    .state_i (state),
    .idx_i   (idx),
    .env_o   (env)
  );

  gr_gain_mul #(.DATA_W(DATA_W), .GAIN_W(GAIN_W), .IDX_W(IDX_W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .data_i  (data_i),
    .gain_i  (gain_i),
    .env_i   (env),
    .valid_o (valid_o),
    .data_o  (data_o)
  );

  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && env_en_i && state == ST_IDLE) |=> (data_o == '0));
endmodule

// File: tb/gain_ramp_stage_test.sv
module gain_ramp_stage_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        env_en_i = 1'b0;
  logic        ramp_req_i = 1'b0;
  logic        shape_i = 1'b0;
  logic [10:0] gain_i = '0;
  logic [15:0] rate_i = '0;
  logic        valid_i = 1'b0;
  logic [15:0] data_i = '0;
  logic        valid_o;
  logic [15:0] data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_ramp_stage uut (
    .clk_i(clk), .rst_ni(rst_ni), .env_en_i(env_en_i), .ramp_req_i(ramp_req_i),
    .shape_i(shape_i), .gain_i(gain_i), .rate_i(rate_i), .valid_i(valid_i),
    .data_i(data_i), .valid_o(valid_o), .data_o(data_o)
  );

  function automatic int model(int x, int g, int e);
    longint p;
    p = (longint'(x) * g) >>> 11;
    p = (p * e) >>> 7;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  function automatic int sig_env(int k);
    return (384 * k * k - 2 * k * k * k) >>> 14;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample(input int x, output int y);
    valid_i = 1'b1;
    data_i  = 16'(x);
    @(negedge clk);
    y = int'($signed(data_o));
  endtask

  task automatic gap(input int n);
    valid_i = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic to_idle();
    env_en_i = 1'b0; ramp_req_i = 1'b0;
    gap(1);
    env_en_i = 1'b1;
    gap(1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R3 valid_o in reset", int'(valid_o), 0);
    chk("R3 data_o in reset", int'(data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_bypass();
    int y;
    env_en_i = 1'b0;
    gain_i = 11'd2047; sample(-32768, y); chk("R1 gain 2047 min input", y, model(-32768, 2047, 128));
    sample(32767, y); chk("R1 gain 2047 max input", y, model(32767, 2047, 128));
    chk("R2 valid_o follows", int'(valid_o), 1);
    gain_i = 11'd1024; sample(1001, y); chk("R1 half gain floor", y, 500);
    gain_i = 11'd1;    sample(-3, y);   chk("R11 negative floors to -1", y, -1);
    gain_i = 11'd0;    sample(12345, y); chk("R1 zero gain", y, 0);
    gain_i = 11'd700;  sample(-20000, y); chk("R11 negative truncation", y, model(-20000, 700, 128));
    gap(2);
    chk("R2 valid_o low without strobe", int'(valid_o), 0);
    chk("R2 data_o holds", int'($signed(data_o)), model(-20000, 700, 128));
  endtask

  task automatic t_idle_zero();
    int y;
    env_en_i = 1'b1; ramp_req_i = 1'b0; gain_i = 11'd1024;
    gap(1);
    sample(16384, y); chk("R4 idle envelope gives zero", y, 0);
    sample(-16384, y); chk("R4 idle envelope negative input", y, 0);
    gap(1);
  endtask

  task automatic t_ramp(input bit sig);
    int y, bad_up, bad_dn;
    string tag;
    tag = sig ? "R7" : "R6";
    shape_i = sig; rate_i = 16'd0; gain_i = 11'd1024;
    to_idle();
    ramp_req_i = 1'b1;
    gap(1);
    bad_up = 0;
    for (int k = 0; k < 128; k++) begin
      sample(16384, y);
      if (y != model(16384, 1024, sig ? sig_env(k) : k)) begin
        if (bad_up == 0) chk({tag, " R5 attack sample"}, y, model(16384, 1024, sig ? sig_env(k) : k));
        bad_up++;
      end
    end
    if (bad_up == 0) chk({tag, " R5 attack curve complete"}, 0, 0);
    sample(16384, y); chk("R8 hold at full scale", y, 8192);
    gap(3);
    sample(16384, y); chk("R8 hold persists while requested", y, 8192);
    ramp_req_i = 1'b0;
    gap(1);
    bad_dn = 0;
    for (int k = 127; k >= 0; k--) begin
      sample(16384, y);
      if (y != model(16384, 1024, sig ? sig_env(k) : k)) begin
        if (bad_dn == 0) chk({tag, " R9 decay sample"}, y, model(16384, 1024, sig ? sig_env(k) : k));
        bad_dn++;
      end
    end
    if (bad_dn == 0) chk({tag, " R9 decay curve complete"}, 0, 0);
    sample(16384, y); chk("R9 back to idle after decay", y, 0);
    gap(1);
  endtask

  task automatic t_rate();
    int y;
    shape_i = 1'b0; rate_i = 16'd3; gain_i = 11'd1024;
    to_idle();
    ramp_req_i = 1'b1;
    gap(2);
    for (int j = 0; j < 12; j++) begin
      sample(16384, y);
      chk("R5 prescale 3 step timing", y, 64 * (j / 4));
      if (j % 3 == 2) gap(2);
    end
    env_en_i = 1'b0;
    sample(16384, y); chk("R10 disabled gives full gain", y, 8192);
    env_en_i = 1'b1; ramp_req_i = 1'b0;
    sample(16384, y); chk("R10 ramp state cleared", y, 0);
    gap(1);
  endtask

  task automatic t_abort();
    int y;
    shape_i = 1'b0; rate_i = 16'd0; gain_i = 11'd1024;
    to_idle();
    ramp_req_i = 1'b1;
    gap(1);
    for (int k = 0; k < 10; k++) sample(16384, y);
    chk("R5 mid attack level", y, 64 * 9);
    env_en_i = 1'b0; ramp_req_i = 1'b0;
    sample(16384, y); chk("R10 same-sample full scale", y, 8192);
    env_en_i = 1'b1;
    sample(16384, y); chk("R10 attack does not resume", y, 0);
    gap(1);
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_idle_zero();
    t_ramp(1'b0);
    t_ramp(1'b1);
    t_rate();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule